// File: doc/BRIEF.md
# Carrier-Gated FSK Data Output

This block sits behind a caller-identification FSK demodulator. It takes two inputs that are already sliced to one bit: an energy-present flag from the band detector and the demodulated data bit. A one-bit strobe marks the bit boundaries. A 1 ms tick enable is the time base for all of the block's timing. The block produces an active-low carrier flag that is debounced in both directions. It also produces two data streams that depend on that flag.

The carrier flag asserts only after a set number of consecutive ticks with energy present. Once asserted, the flag rides through short dropouts and releases only after a set number of consecutive ticks without energy. The raw stream copies the data bit whenever the carrier flag is low and idles at 1 otherwise. The cooked stream also needs a validated leader before it passes data. The leader is a long run of alternating bits, then a repeated 1, then an unbroken mark lasting a set number of ticks. As a result, the alternating seizure pattern never reaches the cooked stream.

Top module: `fsk_carrier_gate`

## Requirements
- R1: With energy present at each tick, `carrierN` stays 1 after ACQ_TICKS-1 consecutive ticks and falls to 0 at the clock edge of the ACQ_TICKS-th tick (default 14).
- R2: A tick without energy during acquisition restarts the acquisition count, so a full ACQ_TICKS consecutive energy ticks are needed after it.
- R3: While `carrierN` is 0, a run of fewer than HOLD_TICKS consecutive ticks without energy does not release the flag or the validation, and a tick with energy restarts the dropout count.
- R4: `carrierN` returns to 1 at the clock edge of the HOLD_TICKS-th consecutive tick without energy (default 8).
- R5: While `carrierN` is 0, `rawOut` equals `dataBit` as sampled at the same clock edge. While `carrierN` is 1, including after reset, `rawOut` is 1.
- R6: `cookedOut` is 1 whenever `carrierN` is 1 (including after reset) or validation has not completed, so alternating leader bits never appear on it.
- R7: Validation first needs at least ALT_BITS strobed bits in a row, each different from the previous one (default 16), followed by a strobed 1 that repeats a 1. A shorter alternating run does not qualify, whatever mark follows.
- R8: After the repeated 1, validation completes at the MARK_TICKS-th tick (default 80) during which `dataBit` has been 1 on every cycle. Any cycle with `dataBit` at 0 before that point returns validation to hunting for alternation.
- R9: Once validation has completed and while `carrierN` is 0, `cookedOut` equals `dataBit` as sampled at the same clock edge.
- R10: Validation is cleared when the carrier flag releases, so a newly acquired carrier starts with `cookedOut` held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| tickMs | input | 1 | One-cycle enable every millisecond |
| energyIn | input | 1 | In-band energy present, already sliced |
| dataBit | input | 1 | Demodulated bit level (1 = mark) |
| bitStrobe | input | 1 | One-cycle pulse at each bit centre |
| carrierN | output | 1 | Carrier detect, active low |
| rawOut | output | 1 | Data passed whenever carrier is detected, else 1 |
| cookedOut | output | 1 | Data passed after leader validation, else 1 |

## Verification
An acquisition or hold counter that is off by one shows up as a `carrierN` edge one tick early or late. The bench therefore samples the flag right after the tick before the expected edge and right after the edge tick itself. A validation state machine that qualifies too early shows up as a 0 on `cookedOut` one clock after the bench drives `dataBit` low. The bench probes this after a 15-bit alternating run, after a 79-tick mark, and after a fresh acquisition. A validation state that is lost during a short dropout shows as `cookedOut` stuck at 1 on the next low data bit.

// File: rtl/fskgate_pkg.sv
package fskgate_pkg;

  typedef enum logic [1:0] {
    VAL_HUNT,
    VAL_MARK,
    VAL_OK
  } valState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic acqStep;
    logic acqClear;
    logic holdStep;
    logic holdClear;
    logic runUpdate;
    logic runClear;
    logic markStep;
    logic markClear;
    logic passRaw;
    logic passCooked;
  } gateStrobes_t;

  // Status returned from the datapath to the control
  typedef struct packed {
    logic acqLast;
    logic holdLast;
    logic markLast;
    logic runLong;
    logic prevBit;
  } gateStatus_t;

endpackage

// File: rtl/fskgate_counter.sv
module fskgate_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic step,
  input  logic clear,
  output logic atLast
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)      cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign atLast = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/fskgate_ctrl.sv
module fskgate_ctrl
  import fskgate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickMs,
  input  logic         energyIn,
  input  logic         dataBit,
  input  logic         bitStrobe,
  input  gateStatus_t  stat,
  output gateStrobes_t strb
);
  logic      carrierOn, carrierNext;
  valState_t valState, valNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carrierOn <= 1'b0;
      valState  <= VAL_HUNT;
    end else begin
      carrierOn <= carrierNext;
      valState  <= valNext;
    end
  end

  always_comb begin
    strb        = '0;
    carrierNext = carrierOn;
    valNext     = valState;

    // Carrier acquisition and hold
    if (!carrierOn) begin
      strb.holdClear = 1'b1;
      if (tickMs) begin
        if (!energyIn)         strb.acqClear = 1'b1;
        else if (stat.acqLast) begin
          carrierNext   = 1'b1;
          strb.acqClear = 1'b1;
        end else               strb.acqStep = 1'b1;
      end
    end else begin
      strb.acqClear = 1'b1;
      if (tickMs) begin
        if (energyIn)           strb.holdClear = 1'b1;
        else if (stat.holdLast) begin
          carrierNext    = 1'b0;
          strb.holdClear = 1'b1;
        end else                strb.holdStep = 1'b1;
      end
    end

    // Leader validation
    if (!carrierOn) begin
      valNext        = VAL_HUNT;
      strb.runClear  = 1'b1;
      strb.markClear = 1'b1;
    end else begin
      case (valState)
        VAL_HUNT: begin
          if (bitStrobe) begin
            if (stat.runLong && dataBit && stat.prevBit) begin
              valNext        = VAL_MARK;
              strb.markClear = 1'b1;
              strb.runClear  = 1'b1;
            end else begin
              strb.runUpdate = 1'b1;
            end
          end
        end
        VAL_MARK: begin
          if (!dataBit) begin
            valNext        = VAL_HUNT;
            strb.runClear  = 1'b1;
            strb.markClear = 1'b1;
          end else if (tickMs) begin
            if (stat.markLast) valNext = VAL_OK;
            else               strb.markStep = 1'b1;
          end
        end
        default: ;
      endcase
    end

    strb.passRaw    = carrierNext;
    strb.passCooked = carrierNext && (valNext == VAL_OK);
  end
endmodule

// File: rtl/fskgate_datapath.sv
module fskgate_datapath
  import fskgate_pkg::*;
#(
  parameter int ACQ_TICKS  = 14,
  parameter int HOLD_TICKS = 8,
  parameter int ALT_BITS   = 16,
  parameter int MARK_TICKS = 80
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dataBit,
  input  gateStrobes_t strb,
  output gateStatus_t  stat,
  output logic         carrierN,
  output logic         rawOut,
  output logic         cookedOut
);
  localparam int NUM_CNT = 3;
  localparam int CNT_LIMIT [NUM_CNT] = '{ACQ_TICKS, HOLD_TICKS, MARK_TICKS};
  localparam int RW = $clog2(ALT_BITS + 1);

  logic [NUM_CNT-1:0] cntStep, cntClear, cntLast;

  assign cntStep  = {strb.markStep,  strb.holdStep,  strb.acqStep};
  assign cntClear = {strb.markClear, strb.holdClear, strb.acqClear};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    fskgate_counter #(.LIMIT(CNT_LIMIT[i])) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .step  (cntStep[i]),
      .clear (cntClear[i]),
      .atLast(cntLast[i])
    );
  end

  // Alternating-run length, saturating at ALT_BITS
  logic [RW-1:0] runCnt;
  logic          prevBit;
  logic          runLong;

  assign runLong = (runCnt >= RW'(ALT_BITS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      prevBit <= 1'b0;
    end else if (strb.runClear) begin
      runCnt  <= '0;
    end else if (strb.runUpdate) begin
      prevBit <= dataBit;
      if (runCnt != '0 && dataBit == prevBit) runCnt <= RW'(1);
      else if (!runLong)                      runCnt <= runCnt + 1'b1;
    end
  end

  assign stat.acqLast  = cntLast[0];
  assign stat.holdLast = cntLast[1];
  assign stat.markLast = cntLast[2];
  assign stat.runLong  = runLong;
  assign stat.prevBit  = prevBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carrierN  <= 1'b1;
      rawOut    <= 1'b1;
      cookedOut <= 1'b1;
    end else begin
      carrierN  <= !strb.passRaw;
      rawOut    <= strb.passRaw    ? dataBit : 1'b1;
      cookedOut <= strb.passCooked ? dataBit : 1'b1;
    end
  end
endmodule

// File: rtl/fsk_carrier_gate.sv
module fsk_carrier_gate #(
  parameter int ACQ_TICKS  = 14,
  parameter int HOLD_TICKS = 8,
  parameter int ALT_BITS   = 16,
  parameter int MARK_TICKS = 80
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickMs,
  input  logic energyIn,
  input  logic dataBit,
  input  logic bitStrobe,
  output logic carrierN,
  output logic rawOut,
  output logic cookedOut
);
  fskgate_pkg::gateStrobes_t strb;
  fskgate_pkg::gateStatus_t  stat;

  fskgate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickMs   (tickMs),
    .energyIn (energyIn),
    .dataBit  (dataBit),
    .bitStrobe(bitStrobe),
    .stat     (stat),
    .strb     (strb)
  );

  fskgate_datapath #(
    .ACQ_TICKS (ACQ_TICKS),
    .HOLD_TICKS(HOLD_TICKS),
    .ALT_BITS  (ALT_BITS),
    .MARK_TICKS(MARK_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dataBit  (dataBit),
    .strb     (strb),
    .stat     (stat),
    .carrierN (carrierN),
    .rawOut   (rawOut),
    .cookedOut(cookedOut)
  );
endmodule

// File: rtl/fskgate_checker.sv
module fskgate_checker (
  input logic clk,
  input logic rstN,
  input logic tickMs,
  input logic energyIn,
  input logic dataBit,
  input logic carrierN,
  input logic rawOut,
  input logic cookedOut
);
  AST_CARRIER_ACQ_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carrierN) |-> $past(tickMs && energyIn)); // R1

  AST_CARRIER_REL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carrierN) |-> $past(tickMs && !energyIn)); // R4

  AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !carrierN |-> (rawOut == $past(dataBit))); // R5

  AST_RAW_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    carrierN |-> rawOut); // R5

  AST_COOKED_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    carrierN |-> cookedOut); // R6

  AST_COOKED_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    !cookedOut |-> !rawOut); // R9
endmodule

bind fsk_carrier_gate fskgate_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickMs   (tickMs),
  .energyIn (energyIn),
  .dataBit  (dataBit),
  .carrierN (carrierN),
  .rawOut   (rawOut),
  .cookedOut(cookedOut)
);

// File: tb/fsk_carrier_gate_bench.sv
module fsk_carrier_gate_bench;
  localparam int ACQ  = 14;
  localparam int HOLD = 8;
  localparam int ALT  = 16;
  localparam int MARK = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickMs = 1'b0;
  logic energyIn = 1'b0;
  logic dataBit = 1'b0;
  logic bitStrobe = 1'b0;
  logic carrierN, rawOut, cookedOut;

  always #10 clk = ~clk;

  fsk_carrier_gate #(
    .ACQ_TICKS(ACQ), .HOLD_TICKS(HOLD), .ALT_BITS(ALT), .MARK_TICKS(MARK)
  ) u_fsk_carrier_gate (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .energyIn(energyIn),
    .dataBit(dataBit), .bitStrobe(bitStrobe),
    .carrierN(carrierN), .rawOut(rawOut), .cookedOut(cookedOut)
  );

  typedef struct {
    string req;
    logic  car;
    logic  raw;
    logic  cook;
  } expItem_t;

  expItem_t expQ[$];
  event     sampleEv;
  int       checkCnt = 0;
  int       failCnt  = 0;
  bit       finished = 0;

  // Monitor: pops each expected item and compares at the sample point
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checkCnt++;
        if ((e.car !== 1'bx && carrierN !== e.car) ||
            (e.raw !== 1'bx && rawOut !== e.raw) ||
            (e.cook !== 1'bx && cookedOut !== e.cook)) begin
          failCnt++;
          $display("FAIL %s: carrierN/raw/cooked = %b%b%b expected %b%b%b",
                   e.req, carrierN, rawOut, cookedOut, e.car, e.raw, e.cook);
        end
      end
    end
  end

  task automatic expectOut(input string req, input logic car, input logic raw, input logic cook);
    expItem_t e;
    e.req = req; e.car = car; e.raw = raw; e.cook = cook;
    expQ.push_back(e);
    ->sampleEv;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick(input logic en);
    energyIn = en;
    tickMs   = 1'b1;
    step();
    tickMs   = 1'b0;
    step();
  endtask

  task automatic ticks(input int n, input logic en);
    for (int i = 0; i < n; i++) tick(en);
  endtask

  task automatic sendBit(input logic b);
    dataBit   = b;
    bitStrobe = 1'b1;
    step();
    bitStrobe = 1'b0;
    step();
  endtask

  // Alternating run of n bits starting with first
  task automatic sendAlt(input int n, input logic first);
    logic b;
    b = first;
    for (int i = 0; i < n; i++) begin
      sendBit(b);
      if (!b) expectOut("R6 alternation held off cooked", 1'b0, 1'b0, 1'b1);
      b = ~b;
    end
  endtask

  task automatic probe(input string req, input logic v, input logic car, input logic raw, input logic cook);
    dataBit = v;
    step();
    expectOut(req, car, raw, cook);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    step();
    step();
    step();
    rstN = 1'b1;
    step();
    expectOut("R5 R6 reset state", 1'b1, 1'b1, 1'b1);

    // R2: interrupted acquisition
    ticks(ACQ - 1, 1'b1);
    tick(1'b0);
    ticks(ACQ - 1, 1'b1);
    expectOut("R2 restart after gap", 1'b1, 1'b1, 1'b1);
    expectOut("R1 still idle one tick short", 1'b1, 1'b1, 1'b1);
    tick(1'b1);
    expectOut("R1 asserts at last acquisition tick", 1'b0, 1'b0, 1'b1);

    probe("R5 raw follows 0", 1'b0, 1'b0, 1'b0, 1'b1);
    probe("R5 raw follows 1", 1'b1, 1'b0, 1'b1, 1'b1);

    // R7: run one bit short, then a long mark
    sendAlt(ALT - 1, 1'b1);
    sendBit(1'b1);
    ticks(MARK + 10, 1'b1);
    probe("R7 short alternation not qualified", 1'b0, 1'b0, 1'b0, 1'b1);

    // R8: mark one tick short
    sendAlt(ALT, 1'b0);
    sendBit(1'b1);
    ticks(MARK - 1, 1'b1);
    probe("R8 mark one tick short", 1'b0, 1'b0, 1'b0, 1'b1);

    // R8/R9: full validation
    sendAlt(ALT, 1'b0);
    sendBit(1'b1);
    ticks(MARK, 1'b1);
    probe("R9 cooked passes 0", 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R9 cooked passes 1", 1'b1, 1'b0, 1'b1, 1'b1);

    // R3: short dropouts
    ticks(HOLD - 1, 1'b0);
    expectOut("R3 short dropout holds carrier", 1'b0, 1'b1, 1'b1);
    probe("R3 validation kept through dropout", 1'b0, 1'b0, 1'b0, 1'b0);
    dataBit = 1'b1;
    tick(1'b1);
    ticks(HOLD - 1, 1'b0);
    expectOut("R3 energy tick restarts hold", 1'b0, 1'b1, 1'b1);

    // R4: release edge
    tick(1'b0);
    expectOut("R4 release at last hold tick", 1'b1, 1'b1, 1'b1);
    probe("R5 R6 held high after release", 1'b0, 1'b1, 1'b1, 1'b1);

    // R10: reacquire unvalidated
    ticks(ACQ, 1'b1);
    expectOut("R10 reacquired", 1'b0, 1'b0, 1'b1);
    probe("R10 cooked held after reacquire", 1'b0, 1'b0, 1'b0, 1'b1);

    step();
    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule